// File: doc/BRIEF.md
# Armed single-shot pulse-width capture

This block times one high pulse on an external input against a free-running counter that lives outside it. Software arms the block by setting one bit in a control register. While armed, the first rising edge of the input stores the counter value in a rise-capture register. The next falling edge stores the counter value in a fall-capture register, and the block then disarms itself. Software reads both captures and works out the pulse width as their difference modulo 2^CNT_W.

The arm bit has a guard against accidental setting. A write of 1 takes effect only if software read the control register while the bit was 0, and no other write to the control register came between that read and the write. The capture input passes through a synchronizer before edge detection, so it may be fully asynchronous to the block clock. All register reads return data one clock after the read strobe.

Top module: `pulse_capture`

## Requirements
- R1: After reset the control register, the rise-capture register (address 1) and the fall-capture register (address 2) all read 0x00.
- R2: In the control register (address 0) the arm bit is bit 4. Bits 7..5 and 3..0 always read 0, even after a write of 1 to them.
- R3: A write of 1 to bit 4 of the control register sets the arm bit only if the control register was read with the arm bit at 0 before it. A write of 1 without that read leaves the arm bit at 0.
- R4: Any write to the control register uses up the earlier read of 0. A write of 0 that follows the read makes a later write of 1 ineffective.
- R5: While armed and before any rising edge, a rising edge on cap_in stores cnt_in in the rise-capture register. The stored value is the cnt_in present at the third clock edge at which the new input level is stable (two synchronizer stages plus edge detection).
- R6: After the rising capture, the next falling edge stores cnt_in in the fall-capture register, with the same latency as R5. At that same clock edge the arm bit clears to 0.
- R7: A falling edge seen while armed but before any rising edge stores nothing and leaves the block armed.
- R8: While the arm bit is 0, neither capture register changes.
- R9: Writes to addresses 1 and 2 have no effect. The capture registers are read-only.
- R10: Reads of address 3 return 0x00.
- R11: The captured difference (fall minus rise, modulo 256) equals the number of clock cycles the input was high, across counter wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 control, 1 rise capture, 2 fall capture, 3 unused |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Registered read data, valid the cycle after bus_rd |
| cap_in | input | 1 | Asynchronous pulse input |
| cnt_in | input | 8 | Free-running counter value to capture |

## Verification
The bench uses the default build: an 8-bit counter, a two-stage synchronizer and the arm bit at position 4. An 8-bit counter wraps every 256 cycles. The random pulse starts and widths therefore place many rise/fall pairs across the wrap, which tests the modulo difference of R11 within a short run. The two-stage setting fixes the capture latency at three edges, and the bench's expected counter values are computed from that latency.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL = 2'd0,
    SEL_RISE = 2'd1,
    SEL_FALL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pwc_sync.sv
module pwc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pwc_edge.sv
module pwc_edge (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level;
  end

  assign rise = level & ~prev_q;
  assign fall = ~level & prev_q;
endmodule

// File: rtl/pwc_ctrl.sv
module pwc_ctrl #(
  parameter int DATA_W  = 8,
  parameter int ARM_BIT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic              ctrl_rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_edge,
  input  logic              fall_edge,
  output logic              arm_q,
  output logic              rd_flag,
  output logic              rise_seen,
  output logic              cap_rise_en,
  output logic              cap_fall_en
);
  logic done;

  assign cap_rise_en = arm_q & ~rise_seen & rise_edge;
  assign cap_fall_en = arm_q & rise_seen & fall_edge;
  assign done        = cap_fall_en;

  // Qualifier: read while idle, consumed by any control write
  always_ff @(posedge clk) begin
    if (rst)                  rd_flag <= 1'b0;
    else if (ctrl_wr)         rd_flag <= 1'b0;
    else if (ctrl_rd && !arm_q) rd_flag <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                                      arm_q <= 1'b0;
    else if (ctrl_wr && wdata[ARM_BIT] && rd_flag) arm_q <= 1'b1;
    else if (done)                                arm_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)              rise_seen <= 1'b0;
    else if (!arm_q)      rise_seen <= 1'b0;
    else if (cap_rise_en) rise_seen <= 1'b1;
    else if (done)        rise_seen <= 1'b0;
  end
endmodule

// File: rtl/pulse_capture.sv
module pulse_capture #(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ARM_BIT     = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [pwc_pkg::ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  output logic [DATA_W-1:0]         bus_rdata,
  input  logic                      cap_in,
  input  logic [CNT_W-1:0]          cnt_in
);
  import pwc_pkg::*;

  localparam int PAD_W = DATA_W - CNT_W;

  reg_sel_e   sel;
  logic       cap_sync;
  logic       rise_edge;
  logic       fall_edge;
  logic       ctrl_wr;
  logic       ctrl_rd;
  logic       arm_q;
  logic       rd_flag;
  logic       rise_seen;
  logic       cap_rise_en;
  logic       cap_fall_en;
  logic [CNT_W-1:0] rise_q;
  logic [CNT_W-1:0] fall_q;
  logic [DATA_W-1:0] rd_mux;

  assign sel     = reg_sel_e'(bus_addr);
  assign ctrl_wr = bus_wr && (sel == SEL_CTRL);
  assign ctrl_rd = bus_rd && (sel == SEL_CTRL);

  pwc_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   (cap_in),
    .q   (cap_sync)
  );

  pwc_edge edge_i (
    .clk   (clk),
    .rst   (rst),
    .level (cap_sync),
    .rise  (rise_edge),
    .fall  (fall_edge)
  );

  pwc_ctrl #(.DATA_W(DATA_W), .ARM_BIT(ARM_BIT)) ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .ctrl_wr     (ctrl_wr),
    .ctrl_rd     (ctrl_rd),
    .wdata       (bus_wdata),
    .rise_edge   (rise_edge),
    .fall_edge   (fall_edge),
    .arm_q       (arm_q),
    .rd_flag     (rd_flag),
    .rise_seen   (rise_seen),
    .cap_rise_en (cap_rise_en),
    .cap_fall_en (cap_fall_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      if (cap_rise_en) rise_q <= cnt_in;
      if (cap_fall_en) fall_q <= cnt_in;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_CTRL: rd_mux[ARM_BIT] = arm_q;
      SEL_RISE: rd_mux = {{PAD_W{1'b0}}, rise_q};
      SEL_FALL: rd_mux = {{PAD_W{1'b0}}, fall_q};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/pulse_capture_chk.sv
module pulse_capture_chk #(
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 8,
  parameter int ARM_BIT = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        bus_addr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [CNT_W-1:0]  cnt_in,
  input logic              arm_q,
  input logic              rd_flag,
  input logic              rise_seen,
  input logic              fall_edge,
  input logic              cap_rise_en,
  input logic [CNT_W-1:0]  rise_q,
  input logic [CNT_W-1:0]  fall_q
);
  localparam logic [DATA_W-1:0] RSV_MASK = ~(DATA_W'(1) << ARM_BIT);

  // R3
  arm_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(arm_q) |-> $past(rd_flag));

  // R3
  flag_only_idle_chk: assert property (@(posedge clk) disable iff (rst)
    rd_flag |-> !arm_q);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !arm_q |=> ($stable(rise_q) && $stable(fall_q)));

  // R6
  disarm_after_pair_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(arm_q) |-> $past(rise_seen && fall_edge));

  // R7
  early_fall_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (arm_q && !rise_seen && fall_edge) |=> (arm_q && $stable(fall_q)));

  // R5
  rise_value_chk: assert property (@(posedge clk) disable iff (rst)
    cap_rise_en |=> (rise_q == $past(cnt_in)));

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && bus_addr == 2'd0) |-> ((bus_rdata & RSV_MASK) == '0));
endmodule

bind pulse_capture pulse_capture_chk #(
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W),
  .ARM_BIT(ARM_BIT)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .bus_addr   (bus_addr),
  .bus_rd     (bus_rd),
  .bus_rdata  (bus_rdata),
  .cnt_in     (cnt_in),
  .arm_q      (arm_q),
  .rd_flag    (rd_flag),
  .rise_seen  (rise_seen),
  .fall_edge  (fall_edge),
  .cap_rise_en(cap_rise_en),
  .rise_q     (rise_q),
  .fall_q     (fall_q)
);

// File: tb/pulse_capture_tb_top.sv
module pulse_capture_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       cap_in = 1'b0;
  logic [7:0] cnt_in = 8'd37;

  int vectors = 0;
  int errors  = 0;
  int cyc     = 0;

  pulse_capture dut_i (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_rdata(bus_rdata),
    .cap_in   (cap_in),
    .cnt_in   (cnt_in)
  );

  always #5 clk = ~clk;

  always @(posedge clk) cnt_in <= cnt_in + 8'd1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  // Latency: level set at a negedge is stored at the third following edge
  function automatic logic [7:0] exp_cap(input logic [7:0] cnt_at_drive);
    return cnt_at_drive + 8'd2;
  endfunction

  function automatic logic [7:0] exp_width(input logic [7:0] r, input logic [7:0] f);
    return f - r;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic arm();
    logic [7:0] d;
    bus_read(2'd0, d);
    bus_write(2'd0, 8'h10);
  endtask

  task automatic pulse(input int w, output logic [7:0] er, output logic [7:0] ef);
    @(negedge clk);
    cap_in = 1'b1; er = exp_cap(cnt_in);
    repeat (w) @(negedge clk);
    cap_in = 1'b0; ef = exp_cap(cnt_in);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [7:0] d, er, ef, r0, f0;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    bus_read(2'd0, d); check("R1 ctrl", d, 8'h00);
    bus_read(2'd1, d); check("R1 rise", d, 8'h00);
    bus_read(2'd2, d); check("R1 fall", d, 8'h00);

    // R4: read of 0, then write 0 consumes it, then write 1 ignored
    bus_read(2'd0, d);
    bus_write(2'd0, 8'h00);
    bus_write(2'd0, 8'h10);
    bus_read(2'd0, d); check("R4 consumed", d, 8'h00);

    // R3: write 1 with no read before it is ignored
    bus_write(2'd0, 8'h00);
    bus_write(2'd0, 8'h10);
    bus_read(2'd0, d); check("R3 no read", d, 8'h00);

    // R2/R3: read then write all ones arms; reserved bits read 0
    bus_write(2'd0, 8'hFF);
    bus_read(2'd0, d); check("R2 reserved", d, 8'h10);

    // R9, R10
    bus_write(2'd1, 8'hAA);
    bus_write(2'd2, 8'h55);
    bus_read(2'd1, d); check("R9 rise ro", d, 8'h00);
    bus_read(2'd2, d); check("R9 fall ro", d, 8'h00);
    bus_read(2'd3, d); check("R10 unused", d, 8'h00);

    // R5/R6 directed pulse
    pulse(7, er, ef);
    bus_read(2'd1, r0); check("R5 rise", r0, er);
    bus_read(2'd2, f0); check("R6 fall", f0, ef);
    bus_read(2'd0, d);  check("R6 disarm", d, 8'h00);

    // R8: pulse while disarmed changes nothing
    pulse(5, er, ef);
    bus_read(2'd1, d); check("R8 rise", d, r0);
    bus_read(2'd2, d); check("R8 fall", d, f0);

    // R7: input high while arming, falling edge first is ignored
    @(negedge clk); cap_in = 1'b1;
    repeat (4) @(negedge clk);
    arm();
    @(negedge clk); cap_in = 1'b0;
    repeat (4) @(negedge clk);
    bus_read(2'd0, d); check("R7 still armed", d, 8'h10);
    bus_read(2'd2, d); check("R7 fall kept", d, f0);
    pulse(3, er, ef);
    bus_read(2'd1, d); check("R7 rise after", d, er);
    bus_read(2'd2, d); check("R7 fall after", d, ef);

    // R11 random widths and starts across counter wrap
    for (int i = 0; i < 200; i++) begin
      int w;
      w = 1 + int'($urandom_range(0, 120));
      repeat ($urandom_range(0, 9)) @(negedge clk);
      arm();
      pulse(w, er, ef);
      bus_read(2'd1, r0); check("R5 rand rise", r0, er);
      bus_read(2'd2, f0); check("R6 rand fall", f0, ef);
      check("R11 width", exp_width(r0, f0), 8'(w));
      bus_read(2'd0, d);  check("R6 rand disarm", d, 8'h00);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule